// File: doc/BRIEF.md
# Context-Indexed Delta Prefetcher

This block watches a stream of demand loads, each carrying the PC of the load instruction and a byte address. It learns the distance in cache blocks between successive accesses that share a program context, and it proposes the next block to fetch. The context used to group accesses is chosen by a static mode input. The choices are one shared context, the first-touched block offset of the page, the load PC, the page number, or one of three pairs built from these.

A per-page table keeps the block offset of the first access seen in each page, so the offset-based contexts stay fixed for the life of a page. The selected context is XOR-folded into a table index. A history table records the last block address per context, and a delta table keeps one candidate stride and a saturating confidence per context. Once a stride is confident, each access produces at most one prefetch address. That address is presented with valid/ready and held until it is taken.

Top module: `ctx_delta_prefetch`

## Requirements
- R1: `mode_i` selects the context. 0 = a single shared context, 1 = first-touched block offset of the page, 2 = load PC, 3 = page number (address bits 31:12), 4 = PC with first-touched offset, 5 = page with first-touched offset, 6 = PC with page. Accesses that differ only outside the selected context train the same entry.
- R2: Both tables are indexed by the 36-bit context folded by XOR of 6-bit slices into 6 bits, so 64 entries each. The full context is kept as a tag. A tag mismatch reallocates the entry with its confidence cleared, and that access issues no prefetch.
- R3: The block offset (address bits 11:6) of the first access to a page is captured and reused for every later access to that page in modes 1, 4 and 5.
- R4: The delta is the current block address minus the context's last block address. It is learned only if it lies in -64..63 and is non-zero. A matching delta increments the 2-bit confidence, saturating at 3. A different delta decrements a non-zero confidence, or, at confidence 0, replaces the stored delta and sets confidence to 1.
- R5: An access whose context entry hits and whose updated confidence is 2 or more yields the prefetch address (block address + stored delta) × 64, block aligned, one cycle after the access.
- R6: In PC modes, when a delta is not learnable (for example when the PC jumps to a new page), the stored confident delta is still applied from the new address. Targets in PC modes may lie in another page.
- R7: In modes 3, 5 and 6 a target outside the accessing page is dropped.
- R8: At most one prefetch is produced per access. While `pf_valid_o` is high and `pf_ready_i` is low, the address is held and new candidates are discarded.
- R9: Mode 7 disables the block: no prefetch, and no table is updated.
- R10: Reset clears `pf_valid_o` and empties all tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Static context selection (0..6), 7 disables |
| acc_valid_i | input | 1 | A demand load is presented this cycle |
| acc_pc_i | input | 16 | PC of the load |
| acc_addr_i | input | 32 | Byte address of the load |
| pf_ready_i | input | 1 | Consumer accepts the prefetch address |
| pf_valid_o | output | 1 | Prefetch address valid |
| pf_addr_o | output | 32 | Block-aligned prefetch byte address |

## Verification
On every cycle the assertions check the output handshake: the address stays held while it is stalled, and no prefetch appears without an access. They also check block alignment of the target, the same-page limit in page modes, and silence in the disabled mode. How confidence climbs and falls, when a stride is replaced, tag reallocation on aliasing, reuse of the first-touched offset across pages, and carrying a PC's stride onto a new page all depend on access history. Only the bench's sequences with known expected addresses can show these.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
    localparam int ADDR_W     = 32;
    localparam int PC_W       = 16;
    localparam int PAGE_SH    = 12;
    localparam int BLK_SH     = 6;
    localparam int OFS_W      = PAGE_SH - BLK_SH;
    localparam int PAGE_W     = ADDR_W - PAGE_SH;
    localparam int BLK_W      = ADDR_W - BLK_SH;
    localparam int CTX_W      = PC_W + PAGE_W;
    localparam int IDX_W      = 6;
    localparam int ENTRIES    = 1 << IDX_W;
    localparam int DELTA_W    = 7;
    localparam int CONF_W     = 2;
    localparam int CONF_ISSUE = 2;
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    typedef enum logic [2:0] {
        CTX_GLOBAL   = 3'd0,
        CTX_OFFSET   = 3'd1,
        CTX_PC       = 3'd2,
        CTX_PAGE     = 3'd3,
        CTX_PC_OFS   = 3'd4,
        CTX_PAGE_OFS = 3'd5,
        CTX_PC_PAGE  = 3'd6,
        CTX_NONE     = 3'd7
    } ctx_mode_e;

    typedef struct packed {
        logic              vld;
        logic [PAGE_W-1:0] tag;
        logic [OFS_W-1:0]  ofs;
    } pofs_ent_t;

    typedef struct packed {
        logic             vld;
        logic [CTX_W-1:0] tag;
        logic [BLK_W-1:0] last;
    } hist_ent_t;

    typedef struct packed {
        logic [DELTA_W-1:0] delta;
        logic [CONF_W-1:0]  conf;
    } dlt_ent_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } pf_reg_t;

    function automatic logic [IDX_W-1:0] fold_idx(input logic [CTX_W-1:0] v);
        logic [IDX_W-1:0] h;
        h = '0;
        for (int i = 0; i < CTX_W; i += IDX_W) begin
            h ^= IDX_W'(v >> i);
        end
        return h;
    endfunction
endpackage

// File: rtl/cdp_first_ofs.sv
module cdp_first_ofs
    import cdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [OFS_W-1:0]  first_ofs_o
);
    pofs_ent_t tbl_d [ENTRIES];
    pofs_ent_t tbl_q [ENTRIES];
    logic [IDX_W-1:0] idx;
    logic             hit;

    always_comb begin
        idx         = fold_idx(CTX_W'(page_i));
        hit         = tbl_q[idx].vld && (tbl_q[idx].tag == page_i);
        first_ofs_o = hit ? tbl_q[idx].ofs : ofs_i;
        tbl_d       = tbl_q;
        if (lookup_i && !hit) begin
            tbl_d[idx] = '{vld: 1'b1, tag: page_i, ofs: ofs_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end
endmodule

// File: rtl/cdp_ctx_sel.sv
module cdp_ctx_sel
    import cdp_pkg::*;
(
    input  logic [2:0]        mode_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFS_W-1:0]  first_ofs_i,
    output logic [CTX_W-1:0]  ctx_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        unique case (ctx_mode_e'(mode_i))
            CTX_GLOBAL:   ctx_o = '0;
            CTX_OFFSET:   ctx_o = CTX_W'(first_ofs_i);
            CTX_PC:       ctx_o = CTX_W'(pc_i);
            CTX_PAGE:     ctx_o = CTX_W'(page_i);
            CTX_PC_OFS:   ctx_o = CTX_W'({pc_i, first_ofs_i});
            CTX_PAGE_OFS: ctx_o = CTX_W'({page_i, first_ofs_i});
            CTX_PC_PAGE:  ctx_o = {pc_i, page_i};
            default:      ctx_o = '0;
        endcase
        idx_o = fold_idx(ctx_o);
    end
endmodule

// File: rtl/cdp_learner.sv
module cdp_learner
    import cdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             learn_i,
    input  logic [CTX_W-1:0] ctx_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             cand_vld_o,
    output logic [BLK_W-1:0] cand_blk_o
);
    hist_ent_t hist_d [ENTRIES];
    hist_ent_t hist_q [ENTRIES];
    dlt_ent_t  dlt_d  [ENTRIES];
    dlt_ent_t  dlt_q  [ENTRIES];

    hist_ent_t          cur_h;
    dlt_ent_t           cur_d;
    dlt_ent_t           nxt_d;
    logic               hit;
    logic [BLK_W-1:0]   diff;
    logic               fits;
    logic               step_ok;
    logic [DELTA_W-1:0] step;

    always_comb begin
        cur_h   = hist_q[idx_i];
        cur_d   = dlt_q[idx_i];
        hit     = cur_h.vld && (cur_h.tag == ctx_i);
        diff    = blk_i - cur_h.last;
        fits    = (&diff[BLK_W-1:DELTA_W-1]) || !(|diff[BLK_W-1:DELTA_W-1]);
        step_ok = hit && fits && (diff != '0);
        step    = diff[DELTA_W-1:0];

        nxt_d = cur_d;
        if (!hit) begin
            nxt_d = '0;
        end else if (step_ok) begin
            if (step == cur_d.delta) begin
                if (cur_d.conf != CONF_MAX) nxt_d.conf = cur_d.conf + 1'b1;
            end else if (cur_d.conf == '0) begin
                nxt_d.delta = step;
                nxt_d.conf  = CONF_W'(1);
            end else begin
                nxt_d.conf = cur_d.conf - 1'b1;
            end
        end

        cand_vld_o = learn_i && hit && (nxt_d.conf >= CONF_W'(CONF_ISSUE));
        cand_blk_o = blk_i + {{(BLK_W-DELTA_W){nxt_d.delta[DELTA_W-1]}}, nxt_d.delta};

        hist_d = hist_q;
        dlt_d  = dlt_q;
        if (learn_i) begin
            hist_d[idx_i] = '{vld: 1'b1, tag: ctx_i, last: blk_i};
            dlt_d[idx_i]  = nxt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                hist_q[i] <= '0;
                dlt_q[i]  <= '0;
            end
        end else begin
            hist_q <= hist_d;
            dlt_q  <= dlt_d;
        end
    end
endmodule

// File: rtl/ctx_delta_prefetch.sv
module ctx_delta_prefetch
    import cdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              acc_valid_i,
    input  logic [PC_W-1:0]   acc_pc_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              pf_ready_i,
    output logic              pf_valid_o,
    output logic [ADDR_W-1:0] pf_addr_o
);
    logic              learn;
    logic              page_mode;
    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;
    logic [BLK_W-1:0]  blk;
    logic [OFS_W-1:0]  first_ofs;
    logic [CTX_W-1:0]  ctx;
    logic [IDX_W-1:0]  idx;
    logic              cand_vld;
    logic [BLK_W-1:0]  cand_blk;
    logic              issue;
    pf_reg_t           pf_d, pf_q;

    assign learn = acc_valid_i && (mode_i != CTX_NONE);
    assign page  = acc_addr_i[ADDR_W-1:PAGE_SH];
    assign ofs   = acc_addr_i[PAGE_SH-1:BLK_SH];
    assign blk   = acc_addr_i[ADDR_W-1:BLK_SH];

    cdp_first_ofs u_first_ofs (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_i   (learn),
        .page_i     (page),
        .ofs_i      (ofs),
        .first_ofs_o(first_ofs)
    );

    cdp_ctx_sel u_ctx_sel (
        .mode_i     (mode_i),
        .pc_i       (acc_pc_i),
        .page_i     (page),
        .first_ofs_i(first_ofs),
        .ctx_o      (ctx),
        .idx_o      (idx)
    );

    cdp_learner u_learner (
        .clk       (clk),
        .rst_n     (rst_n),
        .learn_i   (learn),
        .ctx_i     (ctx),
        .idx_i     (idx),
        .blk_i     (blk),
        .cand_vld_o(cand_vld),
        .cand_blk_o(cand_blk)
    );

    always_comb begin
        page_mode = (mode_i == CTX_PAGE) || (mode_i == CTX_PAGE_OFS)
                 || (mode_i == CTX_PC_PAGE);
        issue = cand_vld
             && (!page_mode || (cand_blk[BLK_W-1:OFS_W] == page));
        pf_d = pf_q;
        if (pf_q.vld && !pf_ready_i) begin
            pf_d = pf_q;
        end else if (issue) begin
            pf_d.vld  = 1'b1;
            pf_d.addr = {cand_blk, {BLK_SH{1'b0}}};
        end else begin
            pf_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pf_q <= '0;
        else        pf_q <= pf_d;
    end

    assign pf_valid_o = pf_q.vld;
    assign pf_addr_o  = pf_q.addr;
endmodule

// File: rtl/cdp_checker.sv
module cdp_checker
    import cdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic              acc_valid_i,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic              pf_ready_i,
    input logic              pf_valid_o,
    input logic [ADDR_W-1:0] pf_addr_o
);
    logic stalled;
    logic page_mode;
    assign stalled   = pf_valid_o && !pf_ready_i;
    assign page_mode = (mode_i == 3'd3) || (mode_i == 3'd5) || (mode_i == 3'd6);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> (pf_valid_o && $stable(pf_addr_o)));

    assert_one_per_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid_i && !stalled) |=> !pf_valid_o);

    assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |-> (pf_addr_o[BLK_SH-1:0] == '0));

    assert_same_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && page_mode && !stalled) |=>
            (!pf_valid_o || (pf_addr_o[ADDR_W-1:PAGE_SH] == $past(acc_addr_i[ADDR_W-1:PAGE_SH]))));

    assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd7 && !stalled) |=> !pf_valid_o);
endmodule

bind ctx_delta_prefetch cdp_checker u_cdp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .acc_valid_i(acc_valid_i),
    .acc_addr_i (acc_addr_i),
    .pf_ready_i (pf_ready_i),
    .pf_valid_o (pf_valid_o),
    .pf_addr_o  (pf_addr_o)
);

// File: tb/tb_ctx_delta_prefetch.sv
module tb_ctx_delta_prefetch;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;
    localparam int NVEC       = 15;

    typedef struct packed {
        logic [15:0] pc;
        logic [31:0] addr;
        logic        vld;
        logic [31:0] exp;
    } vec_t;

    // PC mode (2): two interleaved PCs, confidence rise/fall, page jump, page crossing
    localparam vec_t VECS [NVEC] = '{
        '{16'h0100, 32'h0001_0000, 1'b0, 32'h0},
        '{16'h0200, 32'h0003_0000, 1'b0, 32'h0},
        '{16'h0100, 32'h0001_0080, 1'b0, 32'h0},
        '{16'h0200, 32'h0003_0040, 1'b0, 32'h0},
        '{16'h0100, 32'h0001_0100, 1'b1, 32'h0001_0180},
        '{16'h0200, 32'h0003_0080, 1'b1, 32'h0003_00C0},
        '{16'h0100, 32'h0001_0180, 1'b1, 32'h0001_0200},
        '{16'h0100, 32'h0002_0000, 1'b1, 32'h0002_0080},
        '{16'h0100, 32'h0002_0080, 1'b1, 32'h0002_0100},
        '{16'h0100, 32'h0002_0FC0, 1'b1, 32'h0002_1040},
        '{16'h0100, 32'h0002_1000, 1'b0, 32'h0},
        '{16'h0100, 32'h0002_1000, 1'b0, 32'h0},
        '{16'h0100, 32'h0002_1040, 1'b0, 32'h0},
        '{16'h0100, 32'h0002_1080, 1'b0, 32'h0},
        '{16'h0100, 32'h0002_10C0, 1'b1, 32'h0002_1100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd2;
    logic        acc_valid_i = 1'b0;
    logic [15:0] acc_pc_i = '0;
    logic [31:0] acc_addr_i = '0;
    logic        pf_ready_i = 1'b1;
    logic        pf_valid_o;
    logic [31:0] pf_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_delta_prefetch dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .acc_valid_i(acc_valid_i),
        .acc_pc_i   (acc_pc_i),
        .acc_addr_i (acc_addr_i),
        .pf_ready_i (pf_ready_i),
        .pf_valid_o (pf_valid_o),
        .pf_addr_o  (pf_addr_o)
    );

    task automatic chk(input string req, input logic ev, input logic [31:0] ea);
        checks++;
        if (pf_valid_o !== ev || (ev && pf_addr_o !== ea)) begin
            errors++;
            $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
                     req, pf_valid_o, pf_addr_o, ev, ea);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic acc(input logic [15:0] pc, input logic [31:0] addr);
        @(negedge clk);
        acc_valid_i = 1'b1;
        acc_pc_i    = pc;
        acc_addr_i  = addr;
        @(posedge clk);
        #1;
        acc_valid_i = 1'b0;
    endtask

    initial begin
        do_reset();
        #1;
        chk("R10 reset state", 1'b0, 32'h0);

        // Vector walk in PC mode: R4 R5 R6
        mode_i = 3'd2;
        for (int i = 0; i < NVEC; i++) begin
            acc(VECS[i].pc, VECS[i].addr);
            chk($sformatf("R4/R5/R6 vector %0d", i), VECS[i].vld, VECS[i].exp);
        end

        // R10: reset forgets the trained stride
        do_reset();
        acc(16'h0100, 32'h0002_1100);
        chk("R10 tables empty after reset", 1'b0, 32'h0);

        // R1: global mode trains across different PCs
        do_reset();
        mode_i = 3'd0;
        acc(16'h0001, 32'h0009_0000);
        acc(16'h0002, 32'h0009_0040);
        acc(16'h0003, 32'h0009_0080);
        chk("R1 global context shared by PCs", 1'b1, 32'h0009_00C0);

        // R1 R7: page mode, same-page limit
        do_reset();
        mode_i = 3'd3;
        acc(16'h0005, 32'h0004_0F00);
        acc(16'h0006, 32'h0004_0F40);
        acc(16'h0007, 32'h0004_0F80);
        chk("R1 page context", 1'b1, 32'h0004_0FC0);
        acc(16'h0008, 32'h0004_0FC0);
        chk("R7 target outside page dropped", 1'b0, 32'h0);

        // R3: first-touched offset reused across pages
        do_reset();
        mode_i = 3'd1;
        acc(16'h0010, 32'h0006_0140);
        acc(16'h0010, 32'h0006_0180);
        acc(16'h0010, 32'h0006_01C0);
        chk("R3 offset context trains", 1'b1, 32'h0006_0200);
        acc(16'h0011, 32'h0007_0140);
        chk("R3 new page same first offset", 1'b1, 32'h0007_0180);
        acc(16'h0012, 32'h0006_0300);
        chk("R3 captured first offset kept", 1'b1, 32'h0006_0340);

        // R2: aliasing PCs 0x0100 and 0x0004 share index 4
        do_reset();
        mode_i = 3'd2;
        acc(16'h0100, 32'h0001_0000);
        acc(16'h0100, 32'h0001_0080);
        acc(16'h0100, 32'h0001_0100);
        chk("R2 trained before alias", 1'b1, 32'h0001_0180);
        acc(16'h0004, 32'h0005_0000);
        chk("R2 alias reallocates", 1'b0, 32'h0);
        acc(16'h0100, 32'h0001_0180);
        chk("R2 original context evicted", 1'b0, 32'h0);

        // R8: hold while stalled
        do_reset();
        pf_ready_i = 1'b0;
        acc(16'h0100, 32'h0001_0000);
        acc(16'h0100, 32'h0001_0080);
        acc(16'h0100, 32'h0001_0100);
        chk("R8 first prefetch", 1'b1, 32'h0001_0180);
        acc(16'h0100, 32'h0001_0180);
        chk("R8 held while not ready", 1'b1, 32'h0001_0180);
        @(negedge clk);
        pf_ready_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 taken and no new access", 1'b0, 32'h0);

        // R9: disabled mode learns nothing
        do_reset();
        mode_i = 3'd7;
        acc(16'h0100, 32'h0001_0000);
        acc(16'h0100, 32'h0001_0080);
        acc(16'h0100, 32'h0001_0100);
        acc(16'h0100, 32'h0001_0180);
        chk("R9 no prefetch when disabled", 1'b0, 32'h0);
        mode_i = 3'd2;
        acc(16'h0100, 32'h0001_0200);
        chk("R9 no table update when disabled", 1'b0, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule